// File: doc/BRIEF.md
# PLL Output Rate Decoder

This block works out the output frequency that one PLL is producing, using only its configuration and mode settings. It reads a reference frequency value, two configuration words, a control word and a mode register that four PLLs share. From these it returns a 64-bit rate value and a 2-bit status code. The status tells whether the PLL is bypassed, is in a mode other than normal, or is running normally with a computed rate.

A request is made with a one-cycle `start`. When the PLL is bypassed or not in normal mode, the answer is the reference rate, and it is ready one cycle later. When the PLL is in normal mode, the block multiplies the reference by the feedback factor with a shift-and-add multiplier. It then runs a restoring divider twice: first by the reference divisor, then by the output divisor. Each division truncates. `done` pulses once when the result is ready, and the result stays on the outputs until the next request is accepted. The parameter `PLL_SEL` chooses which of the four mode fields this instance decodes.

Top module: `pll_rate_decoder`

## Requirements
- R1: After reset, `busy` and `done` are low, `rate_out` is 0 and `status` is 0.
- R2: The mode of this PLL is `mode_reg[4*PLL_SEL+1 : 4*PLL_SEL]`, where `PLL_SEL` is 0 to 3. The other bits of `mode_reg` have no effect on the result.
- R3: When `ctrl_word[0]` is 1 (bypass), the result is `rate_out` = `ref_rate` and `status` = 0, whatever the mode field holds.
- R4: When bypass is clear and the mode field is not 1 (0 = slow, 2 = deep-slow, 3 = undefined), the result is `rate_out` = `ref_rate` and `status` = 1.
- R5: When bypass is clear and the mode field is 1 (normal), the result uses NF = `cfg_word1[12:0]`, NR = `cfg_word0[13:8]` and OD = `cfg_word0[3:0]`. The rate is floor(floor(ref × (NF+1) / (NR+1)) / (OD+1)), and `status` = 2.
- R6: The result is exact at the extreme field values (NF = 8191, NR = 63, OD = 15, ref = 2^32−1) and at all-zero fields, where the rate equals the reference.
- R7: Each accepted request produces exactly one `done` pulse lasting one cycle. `rate_out` and `status` hold their values after it. A bypass or non-normal request raises `done` in the cycle after `start`.
- R8: A `start` that arrives while `busy` is high is ignored. The inputs are captured when a request is accepted, so input changes during a computation do not alter its result.
- R9: `ctrl_word[5]` (the PLL reset flag) and every other control bit except bit 0 have no effect on the result.
- R10: `busy` is high from the cycle after a normal-mode request is accepted until the cycle in which `done` rises. It stays low for bypass and non-normal requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to decode the current settings |
| ref_rate | input | REF_W | Reference frequency value |
| cfg_word0 | input | CFG_W | Configuration word holding the reference and output dividers |
| cfg_word1 | input | CFG_W | Configuration word holding the feedback divider |
| ctrl_word | input | CFG_W | Control word; bit 0 is bypass |
| mode_reg | input | CFG_W | Shared mode register holding four 2-bit mode fields |
| busy | output | 1 | A normal-mode computation is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| rate_out | output | RATE_W | Decoded output rate |
| status | output | 2 | 0 = bypass, 1 = not normal, 2 = computed |

## Verification
The embedded properties are checked on every cycle. They check the following:
- `status` never takes the code 3.
- `done` never coincides with `busy`.
- A computed status can only come out of the final division step.
- The captured divisors stay stable while a `start` arrives during a computation.
- Each divider pass ends with a remainder below its divisor.
- The multiplier has used up all of its multiplier bits when it finishes.

Only the bench scenarios can show the following:
- The arithmetic results are numerically correct.
- Bypass takes precedence over the mode.
- The other PLLs' mode fields and the control bits other than bit 0 are ignored.
- A request arriving during a computation returns the first request's result with a single `done` pulse.

// File: rtl/pll_rate_pkg.sv
// Shared field positions, status codes and controller states for the PLL
// rate decoder. Assumes field positions fixed by the register layout.
package pll_rate_pkg;
    localparam int MODE_STRIDE = 4;   // distance between per-PLL mode fields
    localparam int NF_W        = 13;  // feedback divider field width
    localparam int NR_W        = 6;   // reference divider field width
    localparam int NR_LSB      = 8;   // reference divider field position
    localparam int OD_W        = 4;   // output divider field width
    localparam logic [1:0] MODE_NORMAL = 2'd1;

    typedef enum logic [1:0] {
        ST_BYPASS     = 2'd0,
        ST_NOT_NORMAL = 2'd1,
        ST_COMPUTED   = 2'd2
    } rate_status_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_MUL    = 2'd1,
        S_DIV_NR = 2'd2,
        S_DIV_OD = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/pll_cfg_decode.sv
// Extracts divider factors, bypass and normal-mode flags from the raw words.
// Assumes CFG_W covers every field and PLL_SEL is in 0..3.
module pll_cfg_decode
    import pll_rate_pkg::*;
#(
    parameter int PLL_SEL = 0,
    parameter int CFG_W   = 32
) (
    input  logic [CFG_W-1:0] cfg_word0,
    input  logic [CFG_W-1:0] cfg_word1,
    input  logic [CFG_W-1:0] ctrl_word,
    input  logic [CFG_W-1:0] mode_reg,
    output logic [NF_W:0]    nf_plus1,
    output logic [NR_W:0]    nr_plus1,
    output logic [OD_W:0]    od_plus1,
    output logic             bypass,
    output logic             normal
);
    localparam int MODE_LSB = PLL_SEL * MODE_STRIDE;

    logic [1:0] mode_fld;
    logic       unused_bits;

    // Field extraction and +1 offsets of the three dividers.
    always_comb begin
        nf_plus1 = {1'b0, cfg_word1[NF_W-1:0]} + (NF_W+1)'(1);
        nr_plus1 = {1'b0, cfg_word0[NR_LSB+NR_W-1:NR_LSB]} + (NR_W+1)'(1);
        od_plus1 = {1'b0, cfg_word0[OD_W-1:0]} + (OD_W+1)'(1);
        mode_fld = mode_reg[MODE_LSB+1:MODE_LSB];
        bypass   = ctrl_word[0];
        normal   = (mode_fld == MODE_NORMAL);
    end

    assign unused_bits = ^{cfg_word0, cfg_word1, ctrl_word, mode_reg};
endmodule

// File: rtl/pll_shift_mult.sv
// Shift-and-add multiplier, one multiplier bit per cycle for B_W cycles.
// Assumes the product fits in A_W bits; start restarts any run in progress.
module pll_shift_mult #(
    parameter int A_W = 64,
    parameter int B_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           done,
    output logic [A_W-1:0] prod
);
    localparam int CNT_W = $clog2(B_W + 1);

    logic [A_W-1:0]   a_q;
    logic [B_W-1:0]   b_q;
    logic [CNT_W-1:0] cnt;
    logic             run;

    // Load operands, then accumulate shifted multiplicand per multiplier bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; prod <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                a_q  <= a_in;
                b_q  <= b_in;
                prod <= '0;
                cnt  <= CNT_W'(B_W);
                run  <= 1'b1;
            end else if (run) begin
                if (b_q[0]) prod <= prod + a_q;
                a_q <= a_q << 1;
                b_q <= b_q >> 1;
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R5
    mul_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (b_q == '0));
endmodule

// File: rtl/pll_restoring_div.sv
// Restoring divider producing one quotient bit per cycle over N cycles.
// Assumes a non-zero divisor below 2**D; the quotient truncates.
module pll_restoring_div #(
    parameter int N = 64,
    parameter int D = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         done,
    output logic [N-1:0] quo
);
    localparam int CNT_W = $clog2(N + 1);

    logic [D-1:0]     rem;
    logic [D-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [D:0]       trial;
    logic             fits;

    // Trial subtraction of the shifted partial remainder.
    always_comb begin
        trial = {rem, quo[N-1]};
        fits  = (trial >= {1'b0, dvs_q});
    end

    // Shift the dividend through the quotient register, restoring on miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0; dvs_q <= '0; quo <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quo   <= dividend;
                dvs_q <= divisor;
                rem   <= '0;
                cnt   <= CNT_W'(N);
                run   <= 1'b1;
            end else if (run) begin
                rem <= fits ? D'(trial - {1'b0, dvs_q}) : trial[D-1:0];
                quo <= {quo[N-2:0], fits};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R5
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < dvs_q));
    // R5
    nonzero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (divisor != '0));
endmodule

// File: rtl/pll_rate_decoder.sv
// Top of the PLL rate decoder: short-circuits bypass and non-normal modes,
// otherwise sequences multiply, divide by NR+1, divide by OD+1.
// Assumes start is a pulse; requests during a computation are dropped.
module pll_rate_decoder
    import pll_rate_pkg::*;
#(
    parameter int PLL_SEL = 0,
    parameter int REF_W   = 32,
    parameter int CFG_W   = 32,
    parameter int RATE_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REF_W-1:0]  ref_rate,
    input  logic [CFG_W-1:0]  cfg_word0,
    input  logic [CFG_W-1:0]  cfg_word1,
    input  logic [CFG_W-1:0]  ctrl_word,
    input  logic [CFG_W-1:0]  mode_reg,
    output logic              busy,
    output logic              done,
    output logic [RATE_W-1:0] rate_out,
    output logic [1:0]        status
);
    localparam int DIV_D = NR_W + 1;
    localparam int MUL_B = NF_W + 1;

    logic [NF_W:0]       nf_plus1;
    logic [NR_W:0]       nr_plus1;
    logic [OD_W:0]       od_plus1;
    logic                bypass, normal;
    ctl_state_e          state;
    rate_status_e        status_q;
    logic [NR_W:0]       nr_q;
    logic [OD_W:0]       od_q;
    logic                mul_start, mul_done, div_start, div_done;
    logic [RATE_W-1:0]   mul_prod, div_quo, div_in;
    logic [DIV_D-1:0]    div_dvs;

    pll_cfg_decode #(.PLL_SEL(PLL_SEL), .CFG_W(CFG_W)) u_dec (
        .cfg_word0(cfg_word0), .cfg_word1(cfg_word1), .ctrl_word(ctrl_word),
        .mode_reg(mode_reg), .nf_plus1(nf_plus1), .nr_plus1(nr_plus1),
        .od_plus1(od_plus1), .bypass(bypass), .normal(normal)
    );

    pll_shift_mult #(.A_W(RATE_W), .B_W(MUL_B)) u_mul (
        .clk(clk), .rst_n(rst_n), .start(mul_start),
        .a_in(RATE_W'(ref_rate)), .b_in(nf_plus1),
        .done(mul_done), .prod(mul_prod)
    );

    pll_restoring_div #(.N(RATE_W), .D(DIV_D)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(div_in), .divisor(div_dvs),
        .done(div_done), .quo(div_quo)
    );

    // Launch conditions and operand routing for the shared divider.
    always_comb begin
        mul_start = (state == S_IDLE) && start && !bypass && normal;
        div_start = ((state == S_MUL) && mul_done) || ((state == S_DIV_NR) && div_done);
        div_in    = (state == S_MUL) ? mul_prod : div_quo;
        div_dvs   = (state == S_MUL) ? DIV_D'(nr_q) : DIV_D'(od_q);
    end

    // Request acceptance, step sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; nr_q <= '0; od_q <= '0;
            rate_out <= '0; status_q <= ST_BYPASS; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    if (bypass) begin
                        rate_out <= RATE_W'(ref_rate); status_q <= ST_BYPASS; done <= 1'b1;
                    end else if (!normal) begin
                        rate_out <= RATE_W'(ref_rate); status_q <= ST_NOT_NORMAL; done <= 1'b1;
                    end else begin
                        nr_q  <= nr_plus1;
                        od_q  <= od_plus1;
                        state <= S_MUL;
                    end
                end
                S_MUL:    if (mul_done) state <= S_DIV_NR;
                S_DIV_NR: if (div_done) state <= S_DIV_OD;
                S_DIV_OD: if (div_done) begin
                    rate_out <= div_quo;
                    status_q <= ST_COMPUTED;
                    done     <= 1'b1;
                    state    <= S_IDLE;
                end
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign busy   = (state != S_IDLE);
    assign status = status_q;

    // R5
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);
    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    computed_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_COMPUTED) |-> $past(state) == S_DIV_OD);
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(nr_q) && $stable(od_q)));
endmodule

// File: tb/sim_pll_rate_decoder.sv
module sim_pll_rate_decoder;
    localparam int SEL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_rate = '0, cfg_word0 = '0, cfg_word1 = '0, ctrl_word = '0, mode_reg = '0;
    logic        busy, done;
    logic [63:0] rate_out;
    logic [1:0]  status;
    int          checks = 0, errors = 0, done_cnt = 0;

    pll_rate_decoder #(.PLL_SEL(SEL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_rate(ref_rate),
        .cfg_word0(cfg_word0), .cfg_word1(cfg_word1), .ctrl_word(ctrl_word),
        .mode_reg(mode_reg), .busy(busy), .done(done),
        .rate_out(rate_out), .status(status)
    );

    always #5ns clk = ~clk;

    always @(negedge clk) if (done) done_cnt++;

    function automatic logic [1:0] exp_status(logic [31:0] ctl, logic [31:0] md);
        if (ctl[0]) return 2'd0;
        if (md[4*SEL +: 2] != 2'd1) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [63:0] exp_rate(logic [31:0] rf, logic [31:0] c0, logic [31:0] c1,
                                             logic [31:0] ctl, logic [31:0] md);
        logic [63:0] v;
        if (exp_status(ctl, md) != 2'd2) return {32'd0, rf};
        v = {32'd0, rf} * ({51'd0, c1[12:0]} + 64'd1);
        v = v / ({58'd0, c0[13:8]} + 64'd1);
        v = v / ({60'd0, c0[3:0]} + 64'd1);
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Drive a request, wait for done, compare against the bench model.
    task automatic run_txn(logic [31:0] rf, logic [31:0] c0, logic [31:0] c1,
                           logic [31:0] ctl, logic [31:0] md, string req);
        logic [63:0] er;
        logic [1:0]  es;
        int          n;
        int          d0;
        er = exp_rate(rf, c0, c1, ctl, md);
        es = exp_status(ctl, md);
        @(negedge clk);
        ref_rate = rf; cfg_word0 = c0; cfg_word1 = c1; ctrl_word = ctl; mode_reg = md;
        start = 1'b1;
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b0;
        if (es != 2'd2) begin
            chk(done == 1'b1, {req, " R7 early done"}, {63'd0, done}, 64'd1);
            chk(busy == 1'b0, {req, " R10 busy idle"}, {63'd0, busy}, 64'd0);
        end else begin
            chk(busy == 1'b1, {req, " R10 busy set"}, {63'd0, busy}, 64'd1);
        end
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(rate_out == er, {req, " rate"}, rate_out, er);
        chk(status == es, {req, " status"}, {62'd0, status}, {62'd0, es});
        @(negedge clk);
        chk(done == 1'b0 && rate_out == er && done_cnt == d0 + 1, {req, " R7 pulse/hold"},
            {32'(done_cnt - d0), 31'd0, done}, {32'd1, 32'd0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog R10", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [31:0] md_norm;
        void'($urandom(32'h5eed_0042));
        md_norm = 32'h1 << (4 * SEL);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && rate_out == 64'd0 && status == 2'd0, "R1 reset",
            {rate_out[31:0], 28'd0, status, busy, done}, 64'd0);
        rst_n = 1'b1;

        run_txn(32'd24000000, 32'h0000_0100, 32'd49, 32'd0, md_norm, "R5 typical");
        chk(rate_out == 64'd600000000, "R5 absolute 600e6", rate_out, 64'd600000000);
        run_txn(32'd24000000, 32'h0000_0100, 32'd49, 32'd1, md_norm, "R3 bypass normal");
        run_txn(32'd12345, 32'h0000_0305, 32'd77, 32'd1, 32'd0, "R3 bypass slow");
        run_txn(32'd9999, 32'h0000_0100, 32'd49, 32'd0, 32'd0, "R4 slow");
        run_txn(32'd9999, 32'h0000_0100, 32'd49, 32'd0, 32'h2 << (4*SEL), "R4 deep");
        run_txn(32'd9999, 32'h0000_0100, 32'd49, 32'd0, 32'h3 << (4*SEL), "R4 mode3");
        // R2: other PLLs normal, own slow -> not normal
        run_txn(32'd777, 32'h0000_0203, 32'd100, 32'd0, 32'h1011, "R2 foreign fields");
        run_txn(32'd777, 32'h0000_0203, 32'd100, 32'd0, 32'hFCFF_FCFF | md_norm, "R2 own normal");
        run_txn(32'hFFFF_FFFF, 32'h0000_3F0F, 32'h0000_1FFF, 32'd0, md_norm, "R6 max");
        chk(rate_out == 64'h7_FFFF_FFF8, "R6 max value", rate_out, 64'h7_FFFF_FFF8);
        run_txn(32'hDEAD_BEEF, 32'd0, 32'd0, 32'd0, md_norm, "R6 zero fields");
        run_txn(32'd24000000, 32'hFFFF_C0FF & 32'hFFFF_0103, 32'hFFFF_E031, 32'hFFFF_FFFE,
                md_norm, "R9 reset flag");
        run_txn(32'd5000, 32'h0000_0001, 32'd3, 32'h0000_0020, md_norm, "R9 bit5 only");

        // R8: second start during computation must be ignored
        begin
            logic [63:0] ea;
            int d0;
            ea = exp_rate(32'd1000000, 32'h0000_0402, 32'd299, 32'd0, md_norm);
            @(negedge clk);
            ref_rate = 32'd1000000; cfg_word0 = 32'h0000_0402; cfg_word1 = 32'd299;
            ctrl_word = 32'd0; mode_reg = md_norm; start = 1'b1;
            d0 = done_cnt;
            @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            ref_rate = 32'd3; cfg_word0 = 32'h0000_0000; cfg_word1 = 32'd0; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (300) @(negedge clk);
            chk(rate_out == ea, "R8 first result kept", rate_out, ea);
            chk(done_cnt == d0 + 1, "R8 single done", 64'(done_cnt - d0), 64'd1);
        end

        for (int i = 0; i < 40; i++) begin
            logic [31:0] rf, c0, c1, ct, md;
            rf = $urandom; c0 = $urandom; c1 = $urandom; ct = $urandom;
            md = $urandom;
            if (($urandom % 8) != 0) ct[0] = 1'b0;
            if (($urandom % 4) != 0) md[4*SEL +: 2] = 2'd1;
            run_txn(rf, c0, c1, ct, md, "R5 random");
        end

        finish_run();
    end
endmodule